// File: doc/BRIEF.md
# Receive Timestamp Capture Bank

This block records the value of a free-running 64-bit nanosecond time bus at the moment a timestamp-worthy packet event happens. A receive event strobe is stored in one of a small bank of capture slots. The index of the chosen slot comes back to the receive path one cycle later, so that the packet descriptor can name the slot and software can fetch the matching stamp afterwards. A single further capture register serves transmit events and can raise an interrupt pulse.

Every capture register latches. Once it holds a stamp it ignores further events until software reads its upper word. That read frees the register. If all receive slots are held, new receive events get no stamp and a drop is flagged. The bank stays in that state until software reads the upper words back. Software sees a slot-occupancy word and a sticky event word, and the event word clears when it is read. All reads go through a word-wide read port with registered data.

Top module: `rx_stamp_bank`

## Requirements
- R1: After synchronous reset all slots and the transmit register are free, and rx_done, rx_drop, tx_irq and rd_data are 0.
- R2: A receive event with at least one free slot stores the time_ns value present at that clock edge into the lowest-numbered free slot. In the next cycle rx_done is 1 and rx_slot carries that slot's index.
- R3: A read of address 2n returns bits 31:0 of slot n and a read of address 2n+1 returns bits 63:32. The data appears on rd_data in the cycle after rd_en. A held slot keeps its stamp while later events arrive.
- R4: Address 2·NUM_SLOTS+2 (10 by default) returns the occupancy word: bit n is 1 while slot n holds a stamp.
- R5: Reading the upper word of a slot frees it. Reading its lower word leaves it held.
- R6: A receive event while every slot is held stores nothing, gives rx_done 0 and pulses rx_drop for one cycle. Reading all upper words frees the whole bank.
- R7: A slot freed by an upper-word read is not free for a receive event in that same cycle. The event sees the slot as held, and the slot can be taken from the next cycle on.
- R8: The transmit register (lower word at address 8, upper word at 9) captures time_ns on tx_evt when free. A tx_evt while it is held is ignored and the held stamp is kept. Reading address 9 frees it.
- R9: tx_irq pulses one cycle after a transmit capture only if tx_irq_en was 1 at the capture edge.
- R10: Address 11 returns the sticky event word: bit 0 transmit captured, bit 1 receive dropped, bit 2 transmit event ignored. The read returns the word and clears it. An event in the same cycle as the clearing read is kept.
- R11: Addresses 12 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | 64 | Current time in nanoseconds |
| rx_evt | input | 1 | Receive event strobe |
| rx_done | output | 1 | Receive stamp captured (one cycle after event) |
| rx_slot | output | IDX_W (2) | Slot index of the capture, valid with rx_done |
| rx_drop | output | 1 | Receive event found no free slot |
| tx_evt | input | 1 | Transmit event strobe |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| tx_irq | output | 1 | Transmit capture interrupt pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Read word address |
| rd_data | output | 32 | Registered read data |

## Verification
Two functions can fall in the same cycle: an upper-word read that frees a slot and a receive event that needs a slot. A clearing read of the event word can also coincide with a new event. Directed steps fill the bank and then issue an event together with the read of slot 1's upper word. The bench expects a drop in that cycle and a capture into slot 1 in the cycle after. A seeded random phase then mixes events and reads of every address at rates that keep the bank saturated much of the time. It compares each output against a cycle model that applies reads before captures.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int unsigned STAMP_W   = 64;
    localparam int unsigned WORD_W    = STAMP_W / 2;
    localparam int unsigned SEL_IDX_W = 8;

    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_RX,
        RD_TX,
        RD_SLOT_STAT,
        RD_EVT_STAT
    } rd_kind_e;

    typedef struct packed {
        rd_kind_e             kind;
        logic                 hi;
        logic [SEL_IDX_W-1:0] slot;
    } rd_sel_t;

    // bit 0 tx captured, bit 1 rx dropped, bit 2 tx ignored
    typedef struct packed {
        logic tx_miss;
        logic rx_drop;
        logic tx_cap;
    } evt_stat_t;

    function automatic word_t word_of(stamp_t v, logic hi);
        return hi ? v[STAMP_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
    parameter  int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 req,
    input  logic [NUM_SLOTS-1:0] busy,
    output logic [NUM_SLOTS-1:0] grant,
    output logic [IDX_W-1:0]     idx,
    output logic                 full
);

    logic [NUM_SLOTS:0] free_below;
    assign free_below[0] = 1'b0;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pick
        assign grant[g]        = req & ~busy[g] & ~free_below[g];
        assign free_below[g+1] = free_below[g] | ~busy[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grant[i]) idx = i[IDX_W-1:0];
        end
    end

    assign full = &busy;

endmodule

// File: rtl/rsb_stamp_reg.sv
module rsb_stamp_reg
    import rsb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap,
    input  logic   unlatch,
    input  stamp_t stamp_in,
    output logic   held,
    output stamp_t stamp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= 1'b0;
            stamp_q <= '0;
        end else begin
            held <= (held & ~unlatch) | cap;
            if (cap) stamp_q <= stamp_in;
        end
    end

    // R2: a capture is only granted to a free register
    p_cap_only_free_r2: assert property (@(posedge clk) disable iff (rst)
        cap |-> !held);

    // R5: an upper-word read releases the held register
    p_unlatch_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (held && unlatch) |=> !held);

    // R3: a held stamp is not disturbed until it is read out
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (held && !unlatch) |=> (held && $stable(stamp_q)));

endmodule

// File: rtl/rsb_read_mux.sv
module rsb_read_mux
    import rsb_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  rd_sel_t                           sel,
    input  logic [NUM_SLOTS-1:0][STAMP_W-1:0] slot_val,
    input  stamp_t                            tx_val,
    input  logic [NUM_SLOTS-1:0]              slot_held,
    input  evt_stat_t                         evst,
    output word_t                             word
);

    always_comb begin
        word = '0;
        case (sel.kind)
            RD_RX:        word = word_of(slot_val[sel.slot[IDX_W-1:0]], sel.hi);
            RD_TX:        word = word_of(tx_val, sel.hi);
            RD_SLOT_STAT: word = WORD_W'(slot_held);
            RD_EVT_STAT:  word = WORD_W'(evst);
            default:      word = '0;
        endcase
    end

endmodule

// File: rtl/rx_stamp_bank.sv
module rx_stamp_bank
    import rsb_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS),
    localparam int unsigned ADDR_W    = $clog2(2 * NUM_SLOTS + 4)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STAMP_W-1:0]  time_ns,
    input  logic                rx_evt,
    output logic                rx_done,
    output logic [IDX_W-1:0]    rx_slot,
    output logic                rx_drop,
    input  logic                tx_evt,
    input  logic                tx_irq_en,
    output logic                tx_irq,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data
);

    localparam logic [ADDR_W-1:0] A_TX_LO = ADDR_W'(2 * NUM_SLOTS);
    localparam logic [ADDR_W-1:0] A_TX_HI = ADDR_W'(2 * NUM_SLOTS + 1);
    localparam logic [ADDR_W-1:0] A_SLOTS = ADDR_W'(2 * NUM_SLOTS + 2);
    localparam logic [ADDR_W-1:0] A_EVTS  = ADDR_W'(2 * NUM_SLOTS + 3);

    rd_sel_t                           sel;
    logic [NUM_SLOTS-1:0]              slot_held;
    logic [NUM_SLOTS-1:0]              grant;
    logic [NUM_SLOTS-1:0]              rx_unlatch;
    logic [NUM_SLOTS-1:0][STAMP_W-1:0] slot_val;
    logic [IDX_W-1:0]                  grant_idx;
    logic                              bank_full;
    logic                              tx_held, tx_cap, tx_unlatch;
    stamp_t                            tx_val;
    evt_stat_t                         evst, evst_set;
    word_t                             rd_word;
    logic                              evt_clear;

    // address decode
    always_comb begin
        sel.kind = RD_NONE;
        sel.hi   = rd_addr[0];
        sel.slot = '0;
        if (rd_addr < A_TX_LO) begin
            sel.kind = RD_RX;
            sel.slot = SEL_IDX_W'(rd_addr >> 1);
        end else if (rd_addr == A_TX_LO || rd_addr == A_TX_HI) begin
            sel.kind = RD_TX;
        end else if (rd_addr == A_SLOTS) begin
            sel.kind = RD_SLOT_STAT;
        end else if (rd_addr == A_EVTS) begin
            sel.kind = RD_EVT_STAT;
        end
    end

    rsb_alloc #(.NUM_SLOTS(NUM_SLOTS)) alloc_i (
        .req   (rx_evt),
        .busy  (slot_held),
        .grant (grant),
        .idx   (grant_idx),
        .full  (bank_full)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign rx_unlatch[g] = rd_en && sel.kind == RD_RX && sel.hi
                               && sel.slot == SEL_IDX_W'(g);
        rsb_stamp_reg slot_i (
            .clk      (clk),
            .rst      (rst),
            .cap      (grant[g]),
            .unlatch  (rx_unlatch[g]),
            .stamp_in (time_ns),
            .held     (slot_held[g]),
            .stamp_q  (slot_val[g])
        );
    end

    assign tx_cap     = tx_evt & ~tx_held;
    assign tx_unlatch = rd_en && sel.kind == RD_TX && sel.hi;

    rsb_stamp_reg tx_reg_i (
        .clk      (clk),
        .rst      (rst),
        .cap      (tx_cap),
        .unlatch  (tx_unlatch),
        .stamp_in (time_ns),
        .held     (tx_held),
        .stamp_q  (tx_val)
    );

    rsb_read_mux #(.NUM_SLOTS(NUM_SLOTS)) mux_i (
        .sel       (sel),
        .slot_val  (slot_val),
        .tx_val    (tx_val),
        .slot_held (slot_held),
        .evst      (evst),
        .word      (rd_word)
    );

    assign evt_clear        = rd_en && sel.kind == RD_EVT_STAT;
    assign evst_set.tx_miss = tx_evt & tx_held;
    assign evst_set.rx_drop = rx_evt & bank_full;
    assign evst_set.tx_cap  = tx_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            evst    <= '0;
            rx_done <= 1'b0;
            rx_slot <= '0;
            rx_drop <= 1'b0;
            tx_irq  <= 1'b0;
            rd_data <= '0;
        end else begin
            evst    <= (evt_clear ? evt_stat_t'('0) : evst) | evst_set;
            rx_done <= |grant;
            rx_slot <= grant_idx;
            rx_drop <= rx_evt & bank_full;
            tx_irq  <= tx_cap & tx_irq_en;
            if (rd_en) rd_data <= rd_word;
        end
    end

    // R2: at most one slot is granted, and never a held one
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & slot_held) == '0));

    // R6: an event into a full bank is reported as dropped, not captured
    p_drop_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_evt && (&slot_held)) |=> (rx_drop && !rx_done));

    // R9: an interrupt pulse needs the enable at the capture edge
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(tx_irq_en));

    // R10: a clearing read with no new event leaves the event word empty
    p_evt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_clear && !rx_evt && !tx_evt) |=> (evst == '0));

endmodule

// File: tb/rx_stamp_bank_tb_top.sv
module rx_stamp_bank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] time_ns;
    logic        rx_evt, tx_evt, tx_irq_en, rd_en;
    logic [3:0]  rd_addr;
    logic        rx_done, rx_drop, tx_irq;
    logic [1:0]  rx_slot;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    // bench model of the bank
    logic [63:0] m_val [4];
    logic [3:0]  m_held;
    logic [63:0] m_tx_val;
    logic        m_tx_held;
    logic [2:0]  m_evst;
    logic [63:0] now_ns;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_stamp_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .time_ns   (time_ns),
        .rx_evt    (rx_evt),
        .rx_done   (rx_done),
        .rx_slot   (rx_slot),
        .rx_drop   (rx_drop),
        .tx_evt    (tx_evt),
        .tx_irq_en (tx_irq_en),
        .tx_irq    (tx_irq),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a < 4'd8)        return a[0] ? m_val[a[2:1]][63:32] : m_val[a[2:1]][31:0];
        else if (a == 4'd8)  return m_tx_val[31:0];
        else if (a == 4'd9)  return m_tx_val[63:32];
        else if (a == 4'd10) return {28'd0, m_held};
        else if (a == 4'd11) return {29'd0, m_evst};
        return 32'd0;
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        if (a < 4'd8)        return "R3 slot word";
        else if (a < 4'd10)  return "R8 tx word";
        else if (a == 4'd10) return "R4 occupancy";
        else if (a == 4'd11) return "R10 event word";
        return "R11 unmapped";
    endfunction

    task automatic step(input logic rx, input logic tx, input logic en,
                        input logic rd, input logic [3:0] addr);
        logic [31:0] e_rd;
        logic        e_done, e_drop, e_irq, tx_take;
        logic [1:0]  e_slot;
        int          fs;
        e_rd = model_read(addr);
        fs = -1;
        for (int i = 3; i >= 0; i--) if (!m_held[i]) fs = i;
        e_done  = rx && fs >= 0;
        e_drop  = rx && fs < 0;
        e_slot  = (fs >= 0) ? 2'(fs) : 2'd0;
        tx_take = tx && !m_tx_held;
        e_irq   = tx_take && en;
        rx_evt = rx; tx_evt = tx; tx_irq_en = en; rd_en = rd; rd_addr = addr;
        time_ns = now_ns;
        @(posedge clk);
        #1;
        rx_evt = 1'b0; tx_evt = 1'b0; rd_en = 1'b0;
        // reads act before captures (R7)
        if (rd && addr < 4'd8 && addr[0]) m_held[addr[2:1]] = 1'b0;
        if (e_done) begin m_held[fs] = 1'b1; m_val[fs] = now_ns; end
        if (rd && addr == 4'd11) m_evst = 3'd0;
        m_evst = m_evst | {tx && m_tx_held, e_drop, tx_take};
        if (rd && addr == 4'd9) m_tx_held = 1'b0;
        if (tx_take) begin m_tx_held = 1'b1; m_tx_val = now_ns; end
        chk(64'(rx_done), 64'(e_done), "R2 rx_done");
        if (e_done) chk(64'(rx_slot), 64'(e_slot), "R2 lowest free slot index");
        chk(64'(rx_drop), 64'(e_drop), "R6 rx_drop");
        chk(64'(tx_irq), 64'(e_irq), "R9 tx_irq");
        if (rd) chk(64'(rd_data), 64'(e_rd), read_tag(addr));
        now_ns = now_ns + 64'd1600 + 64'($urandom % 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; rx_evt = 1'b0; tx_evt = 1'b0; tx_irq_en = 1'b0;
        rd_en = 1'b0; rd_addr = '0; time_ns = '0;
        now_ns = 64'h0000_0123_89ab_0000;
        m_held = '0; m_tx_held = 1'b0; m_evst = '0; m_tx_val = '0;
        for (int i = 0; i < 4; i++) m_val[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk(64'(rx_done), 0, "R1 rx_done after reset");
        chk(64'(rx_drop), 0, "R1 rx_drop after reset");
        chk(64'(tx_irq), 0, "R1 tx_irq after reset");
        chk(64'(rd_data), 0, "R1 rd_data after reset");
        step(0, 0, 0, 1, 4'd10);
        chk(64'(rd_data), 0, "R1 no slot held after reset");

        // R2: fill the bank in slot order
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 4'd0);
        step(0, 0, 0, 1, 4'd2);
        step(0, 0, 0, 1, 4'd10);
        chk(64'(rd_data), 64'hf, "R5 lower-word read keeps slot held");

        // R6: full bank drops
        step(1, 0, 0, 0, 4'd0);
        chk(64'(rx_drop), 1, "R6 drop with full bank");

        // R7: free and capture in the same cycle
        step(1, 0, 0, 1, 4'd3);
        chk(64'(rx_drop), 1, "R7 freed slot not usable in same cycle");
        step(1, 0, 0, 0, 4'd0);
        chk(64'(rx_done), 1, "R7 freed slot usable next cycle");
        chk(64'(rx_slot), 1, "R7 freed slot index");

        // R6: recovery by reading every upper word
        step(0, 0, 0, 1, 4'd1);
        step(0, 0, 0, 1, 4'd3);
        step(0, 0, 0, 1, 4'd5);
        step(0, 0, 0, 1, 4'd7);
        step(0, 0, 0, 1, 4'd10);
        chk(64'(rd_data), 0, "R6 bank recovered");

        // R8/R9/R10: transmit register
        step(0, 1, 1, 0, 4'd0);
        chk(64'(tx_irq), 1, "R9 irq with enable");
        step(0, 1, 1, 1, 4'd8);
        step(0, 0, 0, 1, 4'd11);
        chk(64'(rd_data), 64'h7, "R10 event word bits");
        step(0, 0, 0, 1, 4'd11);
        chk(64'(rd_data), 0, "R10 event word cleared by read");
        step(0, 0, 0, 1, 4'd9);
        step(0, 1, 0, 0, 4'd0);
        chk(64'(tx_irq), 0, "R9 irq gated off");
        step(0, 0, 0, 1, 4'd13);
        chk(64'(rd_data), 0, "R11 unmapped reads zero");

        // seeded random mix
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 10) < 3, ($urandom % 20) < 3, 1'($urandom),
                 1'($urandom), 4'($urandom % 14));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule